// File: doc/BRIEF.md
# I2C Bus Hang Recovery Sequencer

This block sits beside an I2C master and frees a bus that a peripheral has left stuck. It watches the two open-drain lines through a short synchronizer. It flags a hang in two cases: SCL has been held low for longer than any legitimate clock stretch, or SDA has been held low while SCL is high for longer than an idle bus allows. A hang, or a one-cycle request from the surrounding logic, starts a recovery. A recovery that is already running ignores every further request.

Recovery is a fixed sequence. First both lines are released for one half-period. Then SCL is pulsed up to `PULSES` times (nine by default) while SDA stays released, so that a peripheral caught mid-byte can clock out its remaining bits. If SDA reads high at the end of a pulse's high half, the pulsing stops early. The block then forms a STOP condition: SDA is pulled low while SCL is low, SCL is released, and finally SDA is released while SCL is high. After the STOP the block samples both lines. It reports a recovery if both are high and a failure otherwise, pulses `done`, and returns to idle. Both lines are only ever pulled low or released.

The states are `ST_IDLE`, `ST_PREP`, `ST_CLK_LO`, `ST_CLK_HI`, `ST_STOP_LO`, `ST_STOP_SU` and `ST_STOP_REL`. A trigger moves IDLE to PREP. Each other state lasts one half-period (`HALF_DIV` cycles) and then advances: PREP to CLK_LO, CLK_LO to CLK_HI, CLK_HI back to CLK_LO or on to STOP_LO, STOP_LO to STOP_SU, STOP_SU to STOP_REL, and STOP_REL to IDLE.

Top module: `i2c_unstick`

## Requirements
- R1: While reset is held, and after it, `scl_pull`, `sda_pull`, `busy`, `done`, `recovered`, `failed` and `sda_freed` are all 0 until a trigger occurs.
- R2: SCL low for fewer than `STRETCH_LIMIT` consecutive synchronized cycles starts nothing. Once that run length is reached, a recovery starts.
- R3: SDA low while SCL is high for `SDA_LIMIT` consecutive synchronized cycles starts a recovery.
- R4: `force_req` high in idle starts a recovery at the next clock edge. `busy` is 1 from that edge until the sequence ends, and the result flags clear at that same edge.
- R5: After one released half-period, SCL is pulsed (pulled low for `HALF_DIV` cycles, then released for `HALF_DIV` cycles) at most `PULSES` times. `sda_pull` is 0 during all pulses and is 1 for exactly 2×`HALF_DIV` cycles per recovery.
- R6: At the end of each released SCL half, if synchronized SDA is high, the pulsing stops. `sda_freed` then holds that sampled SDA value (1 when freed early, 0 when all pulses ran with SDA low).
- R7: The STOP is formed as follows: SCL and SDA are pulled together for one half-period, then SDA alone for one half-period, then both are released for one half-period. With a healthy bus this gives exactly one SDA rise while SCL is high.
- R8: At the end of the STOP, `recovered` is set if both synchronized lines are high; otherwise `failed` is set. The two are never 1 together and hold until the next recovery starts.
- R9: `done` is high for exactly one cycle per recovery, and `busy` falls at the same edge.
- R10: A trigger of either kind that arrives while `busy` is 1 is neither acted on nor remembered.
- R11: A recovery with n SCL pulses keeps `busy` high for exactly `HALF_DIV`×(4+2n) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Sensed SCL line level |
| sda_in | input | 1 | Sensed SDA line level |
| force_req | input | 1 | Request a recovery (synchronous, acted on only in idle) |
| scl_pull | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_pull | output | 1 | 1 pulls SDA low, 0 releases it |
| busy | output | 1 | A recovery sequence is running |
| done | output | 1 | One-cycle pulse when a sequence ends |
| recovered | output | 1 | Last sequence ended with both lines high |
| failed | output | 1 | Last sequence ended with a line still low |
| sda_freed | output | 1 | SDA was seen high when pulsing ended |

## Verification
A wrong internal state shows up at the pull outputs within one half-period. An extra or missing pulse changes the count of `scl_pull` rises and the `busy` length by a multiple of `HALF_DIV`. A STOP stage taken out of order shows as a wrong number of `sda_pull` cycles, or as a missing SDA rise while SCL is high. A watcher counter that is off by a few cycles moves the first `busy` cycle outside the window the bench samples around each limit. A result register left uncleared, or a trigger that is latched while busy, appears as a stale flag or a second `busy` burst within tens of cycles of `done`.

// File: rtl/i2c_unstick_pkg.sv
package i2c_unstick_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREP,
        ST_CLK_LO,
        ST_CLK_HI,
        ST_STOP_LO,
        ST_STOP_SU,
        ST_STOP_REL
    } rec_state_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] lines_in,
    output logic [1:0] lines_out
);
    logic [1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[0] <= 2'b11;
        else        stage_q[0] <= lines_in;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[i] <= 2'b11;
            else        stage_q[i] <= stage_q[i-1];
        end
    end

    assign lines_out = stage_q[STAGES-1];
endmodule

// File: rtl/i2c_run_count.sv
module i2c_run_count #(
    parameter int unsigned LIMIT = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cond,
    output logic hit
);
    localparam int unsigned W = $clog2(LIMIT + 1);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  cnt <= '0;
        else if (!cond)              cnt <= '0;
        else if (cnt != W'(LIMIT))   cnt <= cnt + 1'b1;
    end

    assign hit = cond && (cnt == W'(LIMIT));

    // R2 / R3: the run length never passes its limit
    assert_run_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= W'(LIMIT));
endmodule

// File: rtl/i2c_hang_watch.sv
module i2c_hang_watch #(
    parameter int unsigned STRETCH_LIMIT = 5_000_000,
    parameter int unsigned SDA_LIMIT     = 5_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic scl_s,
    input  logic sda_s,
    output logic hang
);
    logic scl_hit, sda_hit;

    i2c_run_count #(.LIMIT(STRETCH_LIMIT)) u_scl_run (
        .clk  (clk),
        .rst_n(rst_n),
        .cond (enable && !scl_s),
        .hit  (scl_hit)
    );

    i2c_run_count #(.LIMIT(SDA_LIMIT)) u_sda_run (
        .clk  (clk),
        .rst_n(rst_n),
        .cond (enable && scl_s && !sda_s),
        .hit  (sda_hit)
    );

    assign hang = scl_hit || sda_hit;

    // R10: no hang is reported while the watcher is disabled
    assert_quiet_when_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> !hang);
endmodule

// File: rtl/i2c_half_timer.sv
module i2c_half_timer #(
    parameter int unsigned HALF_DIV = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int unsigned TW = $clog2(HALF_DIV + 1);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          cnt <= '0;
        else if (!run)                       cnt <= '0;
        else if (cnt == TW'(HALF_DIV - 1))   cnt <= '0;
        else                                 cnt <= cnt + 1'b1;
    end

    assign tick = run && (cnt == TW'(HALF_DIV - 1));

    // R11: the half-period counter stays inside its period
    assert_tick_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < TW'(HALF_DIV));
endmodule

// File: rtl/i2c_unstick.sv
module i2c_unstick
    import i2c_unstick_pkg::*;
#(
    parameter int unsigned HALF_DIV      = 1000,
    parameter int unsigned STRETCH_LIMIT = 5_000_000,
    parameter int unsigned SDA_LIMIT     = 5_000_000,
    parameter int unsigned PULSES        = 9,
    parameter int unsigned SYNC_STAGES   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    input  logic force_req,
    output logic scl_pull,
    output logic sda_pull,
    output logic busy,
    output logic done,
    output logic recovered,
    output logic failed,
    output logic sda_freed
);
    localparam int unsigned PW = $clog2(PULSES + 1);

    rec_state_t    state;
    logic [PW-1:0] pcnt;
    logic [1:0]    lines_s;
    logic          scl_s, sda_s;
    logic          hang, tick, start;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .lines_in ({scl_in, sda_in}),
        .lines_out(lines_s)
    );
    assign scl_s = lines_s[1];
    assign sda_s = lines_s[0];

    i2c_hang_watch #(.STRETCH_LIMIT(STRETCH_LIMIT), .SDA_LIMIT(SDA_LIMIT)) u_watch (
        .clk   (clk),
        .rst_n (rst_n),
        .enable(!busy),
        .scl_s (scl_s),
        .sda_s (sda_s),
        .hang  (hang)
    );

    i2c_half_timer #(.HALF_DIV(HALF_DIV)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (busy),
        .tick (tick)
    );

    assign busy  = (state != ST_IDLE);
    assign start = force_req || hang;

    // State register and the registers that travel with it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            pcnt      <= '0;
            done      <= 1'b0;
            recovered <= 1'b0;
            failed    <= 1'b0;
            sda_freed <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: if (start) begin
                    state     <= ST_PREP;
                    pcnt      <= '0;
                    recovered <= 1'b0;
                    failed    <= 1'b0;
                    sda_freed <= 1'b0;
                end
                ST_PREP:   if (tick) state <= ST_CLK_LO;
                ST_CLK_LO: if (tick) state <= ST_CLK_HI;
                ST_CLK_HI: if (tick) begin
                    pcnt <= pcnt + 1'b1;
                    if (sda_s || (pcnt == PW'(PULSES - 1))) begin
                        state     <= ST_STOP_LO;
                        sda_freed <= sda_s;
                    end else begin
                        state <= ST_CLK_LO;
                    end
                end
                ST_STOP_LO: if (tick) state <= ST_STOP_SU;
                ST_STOP_SU: if (tick) state <= ST_STOP_REL;
                ST_STOP_REL: if (tick) begin
                    state <= ST_IDLE;
                    done  <= 1'b1;
                    if (scl_s && sda_s) recovered <= 1'b1;
                    else                failed    <= 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Output decode: open-drain pull enables only
    always_comb begin
        scl_pull = 1'b0;
        sda_pull = 1'b0;
        unique case (state)
            ST_CLK_LO:  scl_pull = 1'b1;
            ST_STOP_LO: begin
                scl_pull = 1'b1;
                sda_pull = 1'b1;
            end
            ST_STOP_SU: sda_pull = 1'b1;
            default: ;
        endcase
    end

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_busy_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
    assert_start_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(force_req || hang));
    assert_result_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(recovered && failed));
    assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy)) |-> ($stable(recovered) && $stable(failed)));
    assert_pulse_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pcnt <= PW'(PULSES));
    assert_stop_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STOP_REL) |-> ($past(state) == ST_STOP_SU || $past(state) == ST_STOP_REL));
endmodule

// File: tb/i2c_unstick_bench.sv
`timescale 1ns/1ps
module i2c_unstick_bench;
    localparam int H      = 4;
    localparam int SLIM   = 40;
    localparam int DLIM   = 30;
    localparam int NPULSE = 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic force_req = 1'b0;
    logic scl_pull, sda_pull, busy, done, recovered, failed, sda_freed;
    logic scl_line, sda_line;

    // Bench-side peripheral model
    logic scl_arm = 1'b0;
    logic sda_arm = 1'b0;
    int   release_after = 0;
    int   fall_cnt = 0;
    logic scl_prev = 1'b1;
    logic sda_released;

    int total = 0, bad = 0;
    bit finished = 0;

    // Monitor counters (snapshotted by the tasks)
    int n_scl_rise = 0, n_stop = 0, n_busy = 0, n_done = 0, n_sda_pull = 0;
    logic mon_scl_pull_q = 1'b0, mon_sda_q = 1'b1;

    always #2.5 clk = ~clk;

    assign sda_released = (release_after != 0) && (fall_cnt >= release_after);
    assign scl_line = !(scl_pull || scl_arm);
    assign sda_line = !(sda_pull || (sda_arm && !sda_released));

    i2c_unstick #(
        .HALF_DIV(H), .STRETCH_LIMIT(SLIM), .SDA_LIMIT(DLIM),
        .PULSES(NPULSE), .SYNC_STAGES(2)
    ) u_i2c_unstick (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_line), .sda_in(sda_line),
        .force_req(force_req), .scl_pull(scl_pull), .sda_pull(sda_pull),
        .busy(busy), .done(done), .recovered(recovered), .failed(failed),
        .sda_freed(sda_freed)
    );

    always @(posedge clk) begin
        scl_prev <= scl_line;
        if (!sda_arm) fall_cnt <= 0;
        else if (scl_prev && !scl_line) fall_cnt <= fall_cnt + 1;
    end

    always @(negedge clk) begin
        if (scl_pull && !mon_scl_pull_q) n_scl_rise++;
        if (sda_line && !mon_sda_q && scl_line) n_stop++;
        if (busy) n_busy++;
        if (done) n_done++;
        if (sda_pull) n_sda_pull++;
        mon_scl_pull_q = scl_pull;
        mon_sda_q = sda_line;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_done();
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (done) return;
        end
        chk(0, "R9 done never seen", 0, 1);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk({scl_pull, sda_pull, busy, done, recovered, failed, sda_freed} == 7'b0,
            "R1 outputs in reset", int'({scl_pull, sda_pull, busy, done, recovered, failed, sda_freed}), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk({scl_pull, sda_pull, busy, done, recovered, failed, sda_freed} == 7'b0,
            "R1 outputs after reset", int'({scl_pull, sda_pull, busy, done, recovered, failed, sda_freed}), 0);
    endtask

    task automatic t_short_stretch();
        int b0 = n_busy;
        scl_arm = 1'b1;
        repeat (SLIM - 10) @(negedge clk);
        scl_arm = 1'b0;
        repeat (20) @(negedge clk);
        chk(n_busy == b0, "R2 short stretch ignored", n_busy - b0, 0);
    endtask

    task automatic t_long_stretch();
        int b0 = n_busy, r0 = n_scl_rise, s0 = n_stop, p0 = n_sda_pull;
        scl_arm = 1'b1;
        repeat (SLIM - 5) @(negedge clk);
        chk(busy == 1'b0, "R2 no start before limit", busy, 0);
        repeat (15) @(negedge clk);
        chk(busy == 1'b1, "R2 start after limit", busy, 1);
        scl_arm = 1'b0;
        wait_done();
        chk(recovered == 1'b1 && failed == 1'b0, "R8 recovered after stretch", recovered, 1);
        chk(sda_freed == 1'b1, "R6 sda_freed after one pulse", sda_freed, 1);
        chk(n_scl_rise - r0 == 2, "R6 one pulse plus STOP", n_scl_rise - r0, 2);
        chk(n_busy - b0 == H * 6, "R11 busy length n=1", n_busy - b0, H * 6);
        chk(n_stop - s0 == 1, "R7 one STOP edge", n_stop - s0, 1);
        chk(n_sda_pull - p0 == 2 * H, "R5 sda pulled only in STOP", n_sda_pull - p0, 2 * H);
    endtask

    task automatic t_sda_stuck();
        int b0 = n_busy, r0 = n_scl_rise, s0 = n_stop, p0 = n_sda_pull;
        release_after = 5;
        sda_arm = 1'b1;
        repeat (DLIM - 5) @(negedge clk);
        chk(busy == 1'b0, "R3 no start before limit", busy, 0);
        repeat (15) @(negedge clk);
        chk(busy == 1'b1, "R3 start on stuck SDA", busy, 1);
        wait_done();
        sda_arm = 1'b0;
        chk(n_scl_rise - r0 == 6, "R6 early exit after 5 pulses", n_scl_rise - r0, 6);
        chk(sda_freed == 1'b1, "R6 sda_freed set", sda_freed, 1);
        chk(recovered == 1'b1, "R8 recovered after SDA freed", recovered, 1);
        chk(n_stop - s0 == 1, "R7 STOP edge with SCL high", n_stop - s0, 1);
        chk(n_sda_pull - p0 == 2 * H, "R5 SDA released while pulsing", n_sda_pull - p0, 2 * H);
        chk(n_busy - b0 == H * 14, "R11 busy length n=5", n_busy - b0, H * 14);
    endtask

    task automatic t_never_frees();
        int b0 = n_busy, r0 = n_scl_rise, d0 = n_done, s0 = n_stop, b1;
        release_after = 0;
        sda_arm = 1'b1;
        force_req = 1'b1;
        @(negedge clk);
        force_req = 1'b0;
        chk(busy == 1'b1, "R4 force starts next cycle", busy, 1);
        repeat (20) @(negedge clk);
        force_req = 1'b1;
        @(negedge clk);
        force_req = 1'b0;
        wait_done();
        sda_arm = 1'b0;
        chk(n_scl_rise - r0 == NPULSE + 1, "R5 full pulse count", n_scl_rise - r0, NPULSE + 1);
        chk(n_busy - b0 == H * (4 + 2 * NPULSE), "R10 R11 busy length unchanged", n_busy - b0, H * (4 + 2 * NPULSE));
        chk(failed == 1'b1 && recovered == 1'b0, "R8 failed flag", failed, 1);
        chk(sda_freed == 1'b0, "R6 sda_freed clear", sda_freed, 0);
        chk(n_stop - s0 == 0, "R7 no STOP edge on held SDA", n_stop - s0, 0);
        b1 = n_busy;
        repeat (30) @(negedge clk);
        chk(n_done - d0 == 1, "R9 single done pulse", n_done - d0, 1);
        chk(n_busy == b1, "R10 trigger not remembered", n_busy - b1, 0);
        chk(failed == 1'b1, "R8 result held in idle", failed, 1);
    endtask

    task automatic t_clear_on_start();
        int b0 = n_busy;
        force_req = 1'b1;
        @(negedge clk);
        force_req = 1'b0;
        chk(busy == 1'b1, "R4 busy after force", busy, 1);
        chk(failed == 1'b0, "R4 flags cleared at start", failed, 0);
        wait_done();
        chk(recovered == 1'b1, "R8 recovered on clean bus", recovered, 1);
        chk(n_busy - b0 == H * 6, "R11 busy length clean bus", n_busy - b0, H * 6);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_short_stretch();
        t_long_stretch();
        repeat (10) @(negedge clk);
        t_sda_stuck();
        repeat (10) @(negedge clk);
        t_never_frees();
        t_clear_on_start();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule